// File: doc/BRIEF.md
# Receive Byte Queue with Request-to-Send Control

This block sits between a serial receiver and the host. Each byte the receiver shifter completes is written in together with a one-bit error tag. The host pops entries in arrival order through a show-ahead read port. The block tracks how many entries are held, flags the empty and full states, and records in a sticky flag any byte that arrived while there was no room for it.

The block also drives the request-to-send pin. In software mode the pin follows a host-written bit. In hardware mode the pin follows the queue occupancy. A select bit then chooses between two trigger rules. One rule fires when the entry count equals a programmable level mark. The other fires when exactly one slot is still free. The assert condition is computed from the registered count, so the pin drops in the cycle after a read moves the count off the trigger point.

Top module: `rx_fifo_rts`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `full` is 0, `overrun` is 0, and no entry is readable.
- R2: Entries leave in the order they were written. While `empty` is 0, `rd_data` and `rd_err` show the oldest entry, and `rd_en` removes it at the next clock edge.
- R3: A write on its own raises the count by 1. A read on its own lowers it by 1. A write and a read in the same cycle on a non-empty queue leave the count unchanged. A read on an empty queue is ignored.
- R4: A write while the count equals DEPTH (64) is dropped. The count and the stored entries stay unchanged.
- R5: A dropped write sets `overrun` at the next edge. The flag stays set until a cycle with `ovr_clr` high and no dropped write clears it. If both happen in the same cycle, the set wins.
- R6: With `rts_hw` at 0, the asserted state of the pin equals `rts_sw` in the same cycle, whatever the values of `trig_sel`, `level_mark` and the count.
- R7: With `rts_hw` at 1 and `trig_sel` at 0, the pin is asserted exactly when the registered count equals `level_mark`.
- R8: With `rts_hw` at 1 and `trig_sel` at 1, the pin is asserted exactly when the registered count equals DEPTH-1 (63).
- R9: With ACTIVE_LOW=1 (the default), asserted means `rts_pin` is 0 and deasserted means 1. With ACTIVE_LOW=0 the levels are inverted.
- R10: `empty` is 1 exactly when the count is 0. `full` is 1 exactly when the count equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received byte |
| wr_err | input | 1 | Error tag stored with the byte |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 8 | Oldest byte (show-ahead) |
| rd_err | output | 1 | Error tag of the oldest entry |
| level_mark | input | 7 | Occupancy that triggers the pin when `trig_sel` is 0 |
| rts_hw | input | 1 | 1 = pin follows occupancy, 0 = pin follows `rts_sw` |
| trig_sel | input | 1 | 0 = level-mark rule, 1 = one-free-slot rule |
| rts_sw | input | 1 | Software request value |
| ovr_clr | input | 1 | Clear pulse for `overrun` |
| count | output | 7 | Number of entries held |
| empty | output | 1 | Queue holds no entries |
| full | output | 1 | Queue holds DEPTH entries |
| overrun | output | 1 | Sticky flag for a dropped write |
| rts_pin | output | 1 | Request-to-send pin |

## Verification
The hardest state to reach is the top of the queue. The one-free-slot trigger, the full flag, and the race between a dropped write and a clear pulse all need the queue packed to 63 and then 64 entries. The stimulus gets there with 64 back-to-back writes in each trigger mode. It then pushes further writes into the full queue, once alone and once together with `ovr_clr`. It then drains the queue entry by entry, checking the pin against a model occupancy in every cycle of both the fill and the drain.

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts #(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  parameter bit ACTIVE_LOW = 1'b1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_err,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_err,
  input  logic [CW-1:0] level_mark,
  input  logic          rts_hw,
  input  logic          trig_sel,
  input  logic          rts_sw,
  input  logic          ovr_clr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          rts_pin
);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok, rts_req;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;
  assign {rd_err, rd_data} = mem[rp];

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= {wr_err, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
      if (wr_en && full) overrun <= 1'b1;
      else if (ovr_clr)  overrun <= 1'b0;
    end
  end

  assign rts_req = !rts_hw  ? rts_sw :
                   trig_sel ? (count == CW'(DEPTH - 1)) :
                              (count == level_mark);
  assign rts_pin = ACTIVE_LOW ? ~rts_req : rts_req;

endmodule

// File: rtl/rx_fifo_rts_chk.sv
module rx_fifo_rts_chk #(
  parameter int DEPTH = 64,
  parameter bit ACTIVE_LOW = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ovr_clr,
  input logic          rts_hw,
  input logic          trig_sel,
  input logic [CW-1:0] level_mark,
  input logic [CW-1:0] count,
  input logic          empty,
  input logic          full,
  input logic          overrun,
  input logic          rts_pin
);

  a_r3_hold_on_both: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !empty && !full) |=> $stable(count));

  a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty);

  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (full && $stable(count)));

  a_r5_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> overrun);

  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  a_r7_level_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_hw && !trig_sel && count != level_mark) |-> (rts_pin == ACTIVE_LOW));

  a_r8_slot_on: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_hw && trig_sel && count == CW'(DEPTH - 1)) |-> (rts_pin == !ACTIVE_LOW));

  a_r10_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

endmodule

bind rx_fifo_rts rx_fifo_rts_chk #(.DEPTH(DEPTH), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ovr_clr(ovr_clr),
  .rts_hw(rts_hw), .trig_sel(trig_sel), .level_mark(level_mark), .count(count),
  .empty(empty), .full(full), .overrun(overrun), .rts_pin(rts_pin)
);

// File: tb/rx_fifo_rts_bench.sv
module rx_fifo_rts_bench;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_err = 0, rd_en = 0, rts_hw = 0, trig_sel = 0, rts_sw = 0, ovr_clr = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic [6:0] level_mark = '0, count;
  logic rd_err, empty, full, overrun, rts_pin;

  int total = 0, bad = 0;
  bit done = 0;
  logic [8:0] q[$];
  bit m_ovr = 0;

  always #4 clk = ~clk;

  rx_fifo_rts u_rx_fifo_rts (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .level_mark(level_mark),
    .rts_hw(rts_hw), .trig_sel(trig_sel), .rts_sw(rts_sw), .ovr_clr(ovr_clr),
    .count(count), .empty(empty), .full(full), .overrun(overrun), .rts_pin(rts_pin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state();
    bit req;
    string tag;
    int n = q.size();
    chk(int'(count) == n, "R3 count", int'(count), n);
    chk(empty == (n == 0), "R10 empty", int'(empty), int'(n == 0));
    chk(full == (n == DEPTH), "R10 full", int'(full), int'(n == DEPTH));
    chk(overrun == m_ovr, "R5 overrun", int'(overrun), int'(m_ovr));
    if (!rts_hw) begin req = rts_sw; tag = "R6/R9 pin"; end
    else if (trig_sel) begin req = (n == DEPTH - 1); tag = "R8 pin"; end
    else begin req = (n == int'(level_mark)); tag = "R7 pin"; end
    chk(rts_pin == !req, tag, int'(rts_pin), int'(!req));
  endtask

  task automatic cyc(input bit w, input logic [7:0] d, input bit e, input bit r, input bit c);
    bit wok, rok;
    wr_en = w; wr_data = d; wr_err = e; rd_en = r; ovr_clr = c;
    #1;
    if (r && q.size() > 0)
      chk({rd_err, rd_data} == q[0], "R2 order", int'({rd_err, rd_data}), int'(q[0]));
    wok = w && q.size() < DEPTH;
    rok = r && q.size() > 0;
    @(posedge clk);
    if (rok) void'(q.pop_front());
    if (wok) q.push_back({e, d});
    if (w && !wok) m_ovr = 1;
    else if (c) m_ovr = 0;
    #1;
    wr_en = 0; rd_en = 0; ovr_clr = 0;
    #1;
    chk_state();
  endtask

  task automatic t_reset();
    chk(int'(count) == 0 && empty && !full && !overrun, "R1 reset", int'(count), 0);
    chk(rts_pin == 1'b1, "R1/R9 pin idle", int'(rts_pin), 1);
  endtask

  task automatic t_sw_mode();
    rts_hw = 0;
    level_mark = 7'd0;
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 2; s++) begin
        trig_sel = t[0]; rts_sw = s[0];
        cyc(0, 8'h00, 0, 0, 0);
      end
    rts_sw = 0;
    level_mark = 7'd1;
    cyc(1, 8'h5A, 0, 0, 0);
    cyc(0, 8'h00, 0, 1, 0);
  endtask

  task automatic t_simul();
    rts_hw = 1; trig_sel = 0; level_mark = 7'd2;
    cyc(0, 8'h00, 0, 1, 0);
    cyc(1, 8'h11, 1, 0, 0);
    cyc(1, 8'h22, 0, 0, 0);
    cyc(1, 8'h33, 0, 1, 0);
    cyc(1, 8'h44, 1, 1, 0);
    cyc(0, 8'h00, 0, 1, 0);
    cyc(0, 8'h00, 0, 1, 0);
    cyc(0, 8'h00, 0, 1, 0);
  endtask

  task automatic t_fill_drain(input bit trig);
    rts_hw = 1; trig_sel = trig; level_mark = 7'd10;
    for (int i = 0; i < DEPTH; i++)
      cyc(1, 8'(i * 7 + (trig ? 3 : 0)), i[0] ^ i[2], 0, 0);
    cyc(1, 8'hEE, 1, 0, 0);
    cyc(1, 8'hDD, 0, 0, 1);
    cyc(0, 8'h00, 0, 0, 1);
    cyc(0, 8'h00, 0, 0, 0);
    for (int i = 0; i < DEPTH + 1; i++)
      cyc(0, 8'h00, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    t_reset();
    t_sw_mode();
    t_simul();
    t_fill_drain(1'b0);
    t_fill_drain(1'b1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule